// File: doc/BRIEF.md
# Line-Synchronised Sequencer Trigger Generator

This block turns a slow mains line-synchronisation signal (typically 50 Hz or 60 Hz) into a trigger pulse for an event sequencer. The trigger lives in the fast event-clock domain, and everything runs on that one clock, which may run anywhere from 50 MHz to 125 MHz.

The line input is first brought into the clock domain. Each low-to-high transition is then detected and counted, so that only every N-th mains edge is used. A selected edge starts a delay that is counted in 0.1 ms units; a programmable prescaler derives that unit from the event clock. When the delay expires, the trigger is not released at once: it waits for the next rising edge of a periodic coincidence clock, which another counter produces. The trigger is then issued as a single-cycle pulse. Because of this last step, every trigger lands in a fixed phase relation to the machine's revolution clocks.

Top module: `mains_seq_trigger`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `trig_out` is low; every counter, delay and pending state is cleared.
- R2: `line_in` passes through two synchronising flops, and only its low-to-high transitions are counted. A level held high, or a high-to-low transition, yields no further count.
- R3: The divider ratio is `cfg_div` taken as an unsigned number, with the value 0 meaning 256. Exactly one divided edge is produced for every ratio-many counted line rises.
- R4: With `cfg_phase` = K > 0, the delay expires exactly K × P event-clock cycles after the divided edge is accepted, where P is the tick period from R6.
- R5: With `cfg_phase` = 0, the divided edge goes straight on to the retiming stage in the following cycle, without waiting for any tick.
- R6: The 0.1 ms tick period P equals `cfg_tick` in event-clock cycles, and the value 0 is treated as 1. The tick counter restarts whenever a delay is armed.
- R7: `trig_out` rises only in the cycle after a rising edge of `coin_in`, which is sampled as low and then high on consecutive clock edges. That edge must be the first one at or after the cycle in which the delay expires. An expiry with no coincidence edge yet is held pending without limit.
- R8: `trig_out` is exactly one event-clock cycle wide.
- R9: If a new divided edge arrives while a delay is still running, the running delay is discarded and a fresh full delay starts from the new edge, so only one trigger results.
- R10: Several expiries that occur before a single coincidence edge merge into one trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Asynchronous mains line-synchronisation input |
| coin_in | input | 1 | Coincidence clock from a counter in the event-clock domain |
| cfg_div | input | 8 | Line edge divider ratio, 0 means 256 |
| cfg_phase | input | 8 | Phase delay in tick units (0.1 ms each) |
| cfg_tick | input | 16 | Event-clock cycles per tick, 0 means 1 |
| trig_out | output | 1 | Single-cycle sequencer trigger |

## Verification
Each stage fails in its own way at the ports:

- A divider count left over from a wrong state shifts every later trigger by whole mains periods, or removes it outright. The per-cycle comparison catches this at the first missing or extra pulse.
- A wrong tick or delay count shifts the trigger by one or more coincidence periods. This shows up on the first delayed trigger after the fault.
- A lost pending flag drops a trigger whose expiry came before the coincidence edge. A stuck pending flag fires at a coincidence edge with no mains cause. Both are caught within one coincidence period.

// File: rtl/lstrig_pkg.sv
package lstrig_pkg;

    // Default field widths shared by the block and its checker
    localparam int unsigned LS_DIV_W       = 8;
    localparam int unsigned LS_PH_W        = 8;
    localparam int unsigned LS_TICK_W      = 16;
    localparam int unsigned LS_SYNC_STAGES = 2;

    // Retiming stage: waiting for nothing, or holding an expired delay
    typedef enum logic {
        RT_IDLE = 1'b0,
        RT_HOLD = 1'b1
    } rt_state_e;

    // Phase delay stage state
    typedef enum logic {
        PD_IDLE = 1'b0,
        PD_RUN  = 1'b1
    } pd_state_e;

endpackage

// File: rtl/ls_edge_sync.sv
module ls_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    localparam int unsigned LAST = STAGES;

    // pipe[0..STAGES-1] synchronise, pipe[STAGES] holds the previous level
    logic [LAST:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe[0] <= 1'b0;
        end else begin
            pipe[0] <= async_in;
        end
    end

    for (genvar i = 1; i <= LAST; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe[i] <= 1'b0;
            end else begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign rise = pipe[LAST-1] & ~pipe[LAST];

endmodule

// File: rtl/ls_divider.sv
module ls_divider #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             div_pulse
);
    localparam int unsigned CW = DIV_W + 1;

    logic [CW-1:0] ratio;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_inc;

    // A zero setting selects the largest ratio
    assign ratio   = (cfg_div == '0) ? CW'(1) << DIV_W : {1'b0, cfg_div};
    assign cnt_inc = cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            div_pulse <= 1'b0;
        end else begin
            div_pulse <= 1'b0;
            if (rise) begin
                if (cnt_inc >= ratio) begin
                    cnt       <= '0;
                    div_pulse <= 1'b1;
                end else begin
                    cnt <= cnt_inc;
                end
            end
        end
    end

endmodule

// File: rtl/ls_phase_delay.sv
module ls_phase_delay
    import lstrig_pkg::*;
#(
    parameter int unsigned PH_W   = 8,
    parameter int unsigned TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PH_W-1:0]   cfg_phase,
    input  logic [TICK_W-1:0] cfg_tick,
    output logic              done,
    output logic              armed
);
    pd_state_e         state;
    logic [PH_W-1:0]   remain;
    logic [TICK_W-1:0] tick_cnt;
    logic [TICK_W-1:0] tick_last;
    logic              tick_hit;

    assign tick_last = (cfg_tick == '0) ? '0 : cfg_tick - 1'b1;
    assign tick_hit  = (tick_cnt == tick_last);
    assign armed     = (state == PD_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PD_IDLE;
            remain   <= '0;
            tick_cnt <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                // A new edge always restarts the delay from its full length
                tick_cnt <= '0;
                if (cfg_phase == '0) begin
                    state <= PD_IDLE;
                    done  <= 1'b1;
                end else begin
                    state  <= PD_RUN;
                    remain <= cfg_phase;
                end
            end else if (state == PD_RUN) begin
                if (tick_hit) begin
                    tick_cnt <= '0;
                    if (remain == PH_W'(1)) begin
                        state <= PD_IDLE;
                        done  <= 1'b1;
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end else begin
                    tick_cnt <= tick_cnt + 1'b1;
                end
            end else begin
                tick_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/ls_retime.sv
module ls_retime
    import lstrig_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic done,
    input  logic coin_in,
    output logic trig
);
    rt_state_e state;
    logic      coin_q;
    logic      coin_rise;

    assign coin_rise = coin_in & ~coin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            coin_q <= 1'b1;
            state  <= RT_IDLE;
            trig   <= 1'b0;
        end else begin
            coin_q <= coin_in;
            trig   <= 1'b0;
            if (coin_rise && (done || state == RT_HOLD)) begin
                trig  <= 1'b1;
                state <= RT_IDLE;
            end else if (done) begin
                state <= RT_HOLD;
            end
        end
    end

endmodule

// File: rtl/mains_seq_trigger.sv
module mains_seq_trigger
    import lstrig_pkg::*;
#(
    parameter int unsigned DIV_W       = LS_DIV_W,
    parameter int unsigned PH_W        = LS_PH_W,
    parameter int unsigned TICK_W      = LS_TICK_W,
    parameter int unsigned SYNC_STAGES = LS_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_in,
    input  logic              coin_in,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [PH_W-1:0]   cfg_phase,
    input  logic [TICK_W-1:0] cfg_tick,
    output logic              trig_out
);
    logic line_rise;
    logic div_pulse;
    logic dly_done;
    logic dly_armed;

    ls_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (line_in),
        .rise     (line_rise)
    );

    ls_divider #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .rise      (line_rise),
        .cfg_div   (cfg_div),
        .div_pulse (div_pulse)
    );

    ls_phase_delay #(.PH_W(PH_W), .TICK_W(TICK_W)) u_dly (
        .clk       (clk),
        .rst       (rst),
        .start     (div_pulse),
        .cfg_phase (cfg_phase),
        .cfg_tick  (cfg_tick),
        .done      (dly_done),
        .armed     (dly_armed)
    );

    ls_retime u_rt (
        .clk     (clk),
        .rst     (rst),
        .done    (dly_done),
        .coin_in (coin_in),
        .trig    (trig_out)
    );

endmodule

// File: rtl/mains_seq_trigger_chk.sv
module mains_seq_trigger_chk #(
    parameter int unsigned PH_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            line_rise,
    input logic            div_pulse,
    input logic [PH_W-1:0] cfg_phase,
    input logic            dly_done,
    input logic            dly_armed,
    input logic            coin_in,
    input logic            trig_out
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !trig_out);

    p_div_from_rise_r3: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> $past(line_rise));

    p_done_source_r4: assert property (@(posedge clk) disable iff (rst)
        dly_done |-> ($past(div_pulse) || $past(dly_armed)));

    p_zero_phase_r5: assert property (@(posedge clk) disable iff (rst)
        (div_pulse && cfg_phase == '0) |=> dly_done);

    p_trig_on_coin_r7: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> ($past(coin_in) && !$past(coin_in, 2)));

    p_trig_width_r8: assert property (@(posedge clk) disable iff (rst)
        trig_out |=> !trig_out);

    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (div_pulse && cfg_phase != '0) |=> (dly_armed && !dly_done));

endmodule

bind mains_seq_trigger mains_seq_trigger_chk #(.PH_W(PH_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_rise (line_rise),
    .div_pulse (div_pulse),
    .cfg_phase (cfg_phase),
    .dly_done  (dly_done),
    .dly_armed (dly_armed),
    .coin_in   (coin_in),
    .trig_out  (trig_out)
);

// File: tb/mains_seq_trigger_tb.sv
`timescale 1ns/1ps
module mains_seq_trigger_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_in = 1'b0;
    logic        coin_in = 1'b0;
    logic [7:0]  cfg_div = 8'd1;
    logic [7:0]  cfg_phase = 8'd0;
    logic [15:0] cfg_tick = 16'd5;
    logic        trig_out;

    int checks = 0;
    int errors = 0;
    int trig_count = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    mains_seq_trigger u_dut (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .coin_in   (coin_in),
        .cfg_div   (cfg_div),
        .cfg_phase (cfg_phase),
        .cfg_tick  (cfg_tick),
        .trig_out  (trig_out)
    );

    // Coincidence clock: one high cycle per period when enabled
    int coin_period = 4;
    bit coin_en = 1'b1;
    int coin_ctr = 0;
    always @(negedge clk) begin
        if (!coin_en) begin
            coin_in  = 1'b0;
            coin_ctr = 0;
        end else begin
            coin_in  = (coin_ctr == 0);
            coin_ctr = (coin_ctr + 1 >= coin_period) ? 0 : coin_ctr + 1;
        end
    end

    // Behavioural reference: event times kept as cycle numbers
    bit m1, m2, m3, div_now, done_now, pend, coin_prev, exp_trig;
    int mcnt, deadline, n;
    always @(posedge clk) begin
        int p, ratio;
        bit crise, new_done, new_div, rise;
        if (rst) begin
            m1 = 0; m2 = 0; m3 = 0; mcnt = 0; div_now = 0; done_now = 0;
            deadline = -1; pend = 0; coin_prev = 1; exp_trig = 0; n = 0;
        end else begin
            n++;
            p     = (cfg_tick == 0) ? 1 : int'(cfg_tick);
            ratio = (cfg_div == 0) ? 256 : int'(cfg_div);
            crise = coin_in && !coin_prev;
            coin_prev = coin_in;
            exp_trig = 0;
            if (crise && (pend || done_now)) begin
                exp_trig = 1; pend = 0;
            end else if (done_now) begin
                pend = 1;
            end
            new_done = 0;
            if (div_now) begin
                if (cfg_phase == 0) begin new_done = 1; deadline = -1; end
                else deadline = n + int'(cfg_phase) * p;
            end else if (deadline == n) begin
                new_done = 1; deadline = -1;
            end
            rise = m2 && !m3;
            m3 = m2; m2 = m1; m1 = line_in;
            new_div = 0;
            if (rise) begin
                mcnt++;
                if (mcnt >= ratio) begin mcnt = 0; new_div = 1; end
            end
            done_now = new_done;
            div_now  = new_div;
        end
    end

    // Per-cycle comparison away from the active edge
    bit last_trig = 0;
    always @(negedge clk) begin
        checks++;
        if (trig_out !== exp_trig) begin
            errors++;
            $display("FAIL %s cycle %0d: trig_out actual %b expected %b",
                     cur_req, n, trig_out, exp_trig);
        end
        if (trig_out === 1'b1) begin
            trig_count++;
            if (last_trig) begin
                errors++;
                $display("FAIL R8: trig_out actual 2+ cycles wide expected 1");
            end
        end
        last_trig = (trig_out === 1'b1);
    end

    task automatic wait_cyc(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic pulse_line(int high_cyc, int low_cyc);
        @(negedge clk); line_in = 1'b1;
        wait_cyc(high_cyc);
        line_in = 1'b0;
        wait_cyc(low_cyc);
    endtask

    task automatic expect_count(string req, int base, int exp);
        checks++;
        if (trig_count - base != exp) begin
            errors++;
            $display("FAIL %s: trigger count actual %0d expected %0d",
                     req, trig_count - base, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run actual hung expected done");
        finish_run();
    end

    initial begin
        int base;
        // R1: reset state
        wait_cyc(5);
        checks++;
        if (trig_out !== 1'b0) begin
            errors++;
            $display("FAIL R1: trig_out in reset actual %b expected 0", trig_out);
        end
        rst = 1'b0;
        wait_cyc(10);

        // R2 R5 R7: divide by 1, no phase delay
        cur_req = "R5"; base = trig_count;
        cfg_div = 8'd1; cfg_phase = 8'd0; cfg_tick = 16'd5;
        for (int i = 0; i < 3; i++) pulse_line(4, 36);
        expect_count("R5", base, 3);

        // R2: a long high level counts once
        cur_req = "R2"; base = trig_count;
        pulse_line(100, 30);
        expect_count("R2", base, 1);

        // R3 R4: divide by 3, two-tick delay
        cur_req = "R4"; base = trig_count;
        cfg_div = 8'd3; cfg_phase = 8'd2;
        for (int i = 0; i < 9; i++) pulse_line(4, 40);
        expect_count("R3", base, 3);

        // R3: zero setting divides by 256
        cur_req = "R3"; base = trig_count;
        cfg_div = 8'd0; cfg_phase = 8'd0;
        for (int i = 0; i < 255; i++) pulse_line(4, 4);
        wait_cyc(20);
        expect_count("R3", base, 0);
        pulse_line(4, 30);
        expect_count("R3", base, 1);

        // R9: a second edge during the delay restarts it
        cur_req = "R9"; base = trig_count;
        cfg_div = 8'd1; cfg_phase = 8'd10; cfg_tick = 16'd5;
        pulse_line(4, 26);
        pulse_line(4, 100);
        expect_count("R9", base, 1);

        // R6: tick setting zero behaves as one cycle
        cur_req = "R6"; base = trig_count;
        cfg_tick = 16'd0; cfg_phase = 8'd3;
        pulse_line(4, 30);
        expect_count("R6", base, 1);

        // R7 R10: expiries held pending and merged until a coincidence edge
        cur_req = "R10"; base = trig_count;
        cfg_phase = 8'd0; cfg_tick = 16'd5;
        coin_en = 1'b0;
        pulse_line(4, 20);
        pulse_line(4, 30);
        expect_count("R7", base, 0);
        coin_en = 1'b1;
        wait_cyc(20);
        expect_count("R10", base, 1);

        // R4: longer delay, slower coincidence clock
        cur_req = "R4"; base = trig_count;
        coin_period = 7; cfg_phase = 8'd4; cfg_tick = 16'd3;
        pulse_line(4, 60);
        expect_count("R4", base, 1);

        finish_run();
    end

endmodule